// File: doc/BRIEF.md
# I2C Register Target with Time Snapshot

This block is an I2C target that exposes a sixteen-byte register space to a bus host. It oversamples SCL and SDA with a fast system clock, finds START, repeated START and STOP conditions, answers only its own 7-bit address, and moves bytes between the bus and its registers through a pointer that steps after every byte. SDA is never driven high: the block only produces an open-drain pull-down enable.

The space has three kinds of byte. The low seven addresses hold time-of-day values kept by a timekeeper outside the block. Reads of these bytes come from a shadow copy, and writes to them are passed out as single-cycle strobes. The next eight addresses are plain storage, visible on an output bus. The top address is a status byte whose flag bits are set by hardware and can only be cleared by the host. The shadow copy is refreshed at each START, at each STOP, and whenever the pointer steps round to address zero, so a multi-byte read of the time sees one coherent instant even while the time keeps running.

Top module: `i2c_regslave`

## Requirements
- R1: Only the address byte 7'b1101000 (bits 7..1, bit 0 = direction, 0 write / 1 read) is acknowledged by pulling SDA low during the ninth clock; any other address gets no acknowledge, and the bytes that follow until the next START are neither acknowledged nor stored.
- R2: In a write, the first byte after the address loads the pointer from its low four bits; every further byte is acknowledged, stored at the pointer, and the pointer then advances by one.
- R3: The pointer steps from 0Fh to 00h, in writes and in reads alike.
- R4: A read returns bytes MSB first starting at the current pointer, which persists across transfers, so a read without a preceding pointer byte continues from where the last access left off.
- R5: Reads of addresses 00h–06h return the shadow copy, which is loaded from `live_time_i` (byte n in bits 8n+7..8n) on every START and every STOP and holds otherwise.
- R6: The shadow copy is also loaded whenever the pointer steps from 0Fh to 00h.
- R7: A byte written to address 00h–06h produces a one-cycle `time_wr_o` pulse with the address on `time_wr_idx_o` and the byte on `time_wr_data_o`, once per byte.
- R8: Addresses 07h–0Eh are storage bytes that read back what was written; `cfg_regs_o` shows them with address 07h in bits 7..0 and 0Eh in bits 63..56.
- R9: Address 0Fh holds flags in bits 7, 1 and 0 only (other bits read 0); a 1 on `flag_set_i` sets a flag, a written 0 clears it, a written 1 leaves it as it was.
- R10: After the host answers a read byte with NACK the block releases SDA and drives nothing until a new START; a STOP at any point returns it to idle with SDA released.
- R11: After reset SDA is released, the pointer is 00h and storage, flags and shadow read as zero.
- R12: SDA is pulled low only in acknowledge slots of an addressed transfer and for 0 bits of read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| live_time_i | input | 56 | Running time bytes from the timekeeper, byte n at bits 8n+7..8n |
| flag_set_i | input | 8 | Per-bit set requests for the status flags |
| time_wr_o | output | 1 | One-cycle strobe for a host write to a time byte |
| time_wr_idx_o | output | 4 | Address of the time byte written |
| time_wr_data_o | output | 8 | Value written to the time byte |
| cfg_regs_o | output | 64 | Storage bytes 07h..0Eh |
| status_o | output | 8 | Current status flags |

## Verification
The hardest case to reach is the refresh of the shadow copy when a read runs off the top of the space: it only shows when the time changes after the START but before the pointer passes 0Fh, and the byte that follows must then carry the new value rather than the one taken at START. The bench places the pointer at 0Fh, issues a repeated START, changes the time input while the status byte is being shifted out, and compares the next byte with the new time. A second read changes the time after the first byte of a seven-byte burst to show that the rest of the burst still returns the instant taken at START.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } rs_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } rs_kind_e;

  // Address byte hits when the upper seven bits equal the target address.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
    return b[7:1] == own;
  endfunction

  // Flag update: a written 0 clears, a written 1 keeps, hardware sets win.
  function automatic logic [7:0] flag_next(input logic [7:0] q,
                                           input logic [7:0] set,
                                           input logic       clr_en,
                                           input logic [7:0] wdata,
                                           input logic [7:0] mask);
    logic [7:0] kept;
    kept = clr_en ? (q & wdata) : q;
    return (kept | set) & mask;
  endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rs_proto.sv
module i2c_rs_proto
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h68,
  parameter int         NREG     = 16,
  parameter int         PW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_byte,
  output logic          sda_oe,
  output logic [PW-1:0] ptr_q,
  output logic          ptr_inc,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          snap,
  output logic          busy
);

  localparam logic [PW-1:0] LAST = PW'(NREG - 1);

  rs_state_e  st;
  rs_kind_e   kind;
  logic [7:0] shreg;
  logic [7:0] tx_sr;
  logic [3:0] bitcnt;
  logic       rw;
  logic       got_ack;
  logic       ptr_ld;
  logic       quiet;

  assign quiet = ~start_ev & ~stop_ev;

  always_comb begin
    wr_en   = 1'b0;
    ptr_inc = 1'b0;
    ptr_ld  = 1'b0;
    if (quiet && scl_fall) begin
      if (st == ST_RX && bitcnt == 4'd8) begin
        if (kind == BK_PTR)  ptr_ld = 1'b1;
        if (kind == BK_DATA) begin
          wr_en   = 1'b1;
          ptr_inc = 1'b1;
        end
      end
      if (st == ST_TX && bitcnt == 4'd7) ptr_inc = 1'b1;
    end
  end

  assign wr_data = shreg;
  assign snap    = start_ev | stop_ev | (ptr_inc & (ptr_q == LAST));
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ld) begin
      ptr_q <= shreg[PW-1:0];
    end else if (ptr_inc) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= BK_ADDR;
      shreg   <= '0;
      tx_sr   <= '0;
      bitcnt  <= '0;
      rw      <= 1'b0;
      got_ack <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      st     <= ST_RX;
      kind   <= BK_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (kind == BK_ADDR) begin
              if (addr_hit(shreg, TGT_ADDR)) begin
                st     <= ST_ACK;
                rw     <= shreg[0];
                sda_oe <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st     <= ST_ACK;
              sda_oe <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (kind == BK_ADDR && rw) begin
              st     <= ST_TX;
              tx_sr  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              st     <= ST_RX;
              kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st     <= ST_TXACK;
              sda_oe <= 1'b0;
            end else begin
              tx_sr  <= {tx_sr[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
              sda_oe <= ~tx_sr[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            got_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (got_ack) begin
              st     <= ST_TX;
              bitcnt <= '0;
              tx_sr  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs
  import i2c_rs_pkg::*;
#(
  parameter int         NREG       = 16,
  parameter int         TIME_BYTES = 7,
  parameter logic [7:0] FLAG_MASK  = 8'h83,
  parameter int         PW         = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snap,
  input  logic [TIME_BYTES*8-1:0]      live_time,
  input  logic                         wr_en,
  input  logic [PW-1:0]                wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic [PW-1:0]                rd_addr,
  input  logic [7:0]                   flag_set,
  output logic [7:0]                   rd_byte,
  output logic                         time_wr,
  output logic [PW-1:0]                time_wr_idx,
  output logic [7:0]                   time_wr_data,
  output logic [(NREG-TIME_BYTES-1)*8-1:0] cfg_regs,
  output logic [7:0]                   status,
  output logic [TIME_BYTES*8-1:0]      shadow
);

  logic [NREG*8-1:0] rd_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] q;
    if (i < TIME_BYTES) begin : g_time
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (snap) q <= live_time[8*i +: 8];
      end
    end else if (i == NREG - 1) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else q <= flag_next(q, flag_set, wr_en && (wr_addr == PW'(i)), wr_data, FLAG_MASK);
      end
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= '0;
        else if (wr_en && wr_addr == PW'(i))   q <= wr_data;
      end
    end
    assign rd_flat[8*i +: 8] = q;
  end

  assign rd_byte      = rd_flat[{rd_addr, 3'b000} +: 8];
  assign time_wr      = wr_en && (int'(wr_addr) < TIME_BYTES);
  assign time_wr_idx  = wr_addr;
  assign time_wr_data = wr_data;
  assign cfg_regs     = rd_flat[(NREG-1)*8-1 : TIME_BYTES*8];
  assign status       = rd_flat[NREG*8-1 -: 8];
  assign shadow       = rd_flat[TIME_BYTES*8-1 : 0];

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR   = 7'h68,
  parameter int         NREG       = 16,
  parameter int         TIME_BYTES = 7,
  parameter logic [7:0] FLAG_MASK  = 8'h83,
  parameter int         SYNC_STG   = 2,
  localparam int        PW         = $clog2(NREG),
  localparam int        STORE_N    = NREG - TIME_BYTES - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [TIME_BYTES*8-1:0] live_time_i,
  input  logic [7:0]              flag_set_i,
  output logic                    time_wr_o,
  output logic [PW-1:0]           time_wr_idx_o,
  output logic [7:0]              time_wr_data_o,
  output logic [STORE_N*8-1:0]    cfg_regs_o,
  output logic [7:0]              status_o
);

  // Named internal events, also used by the bound checker.
  logic                    sda_s;
  logic                    scl_rise;
  logic                    scl_fall;
  logic                    start_ev;
  logic                    stop_ev;
  logic [7:0]              rd_byte;
  logic [PW-1:0]           ptr_q;
  logic                    ptr_inc;
  logic                    wr_en;
  logic [7:0]              wr_data;
  logic                    snap;
  logic                    busy;
  logic [TIME_BYTES*8-1:0] shadow;

  i2c_rs_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_rs_proto #(.TGT_ADDR(TGT_ADDR), .NREG(NREG), .PW(PW)) u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_byte  (rd_byte),
    .sda_oe   (sda_oe_o),
    .ptr_q    (ptr_q),
    .ptr_inc  (ptr_inc),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .snap     (snap),
    .busy     (busy)
  );

  i2c_rs_regs #(.NREG(NREG), .TIME_BYTES(TIME_BYTES), .FLAG_MASK(FLAG_MASK), .PW(PW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .snap         (snap),
    .live_time    (live_time_i),
    .wr_en        (wr_en),
    .wr_addr      (ptr_q),
    .wr_data      (wr_data),
    .rd_addr      (ptr_q),
    .flag_set     (flag_set_i),
    .rd_byte      (rd_byte),
    .time_wr      (time_wr_o),
    .time_wr_idx  (time_wr_idx_o),
    .time_wr_data (time_wr_data_o),
    .cfg_regs     (cfg_regs_o),
    .status       (status_o),
    .shadow       (shadow)
  );

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
  parameter int NREG       = 16,
  parameter int TIME_BYTES = 7,
  parameter int PW         = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_ev,
  input logic                    stop_ev,
  input logic                    ptr_inc,
  input logic [PW-1:0]           ptr_q,
  input logic                    busy,
  input logic                    sda_oe,
  input logic [TIME_BYTES*8-1:0] live_time,
  input logic [TIME_BYTES*8-1:0] shadow,
  input logic [7:0]              flag_set,
  input logic [7:0]              status,
  input logic                    time_wr,
  input logic [PW-1:0]           time_wr_idx
);

  localparam logic [PW-1:0] LAST = PW'(NREG - 1);

  p_start_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> shadow == $past(live_time));

  p_stop_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> shadow == $past(live_time));

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ev && !stop_ev && !(ptr_inc && ptr_q == LAST)) |=> $stable(shadow));

  p_wrap_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr_q == LAST) |=> shadow == $past(live_time));

  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr_q == LAST) |=> ptr_q == '0);

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

  p_flag_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set == 8'h00) |=> ((status & ~$past(status)) == 8'h00));

  p_idle_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  p_twr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |-> int'(time_wr_idx) < TIME_BYTES);

endmodule

bind i2c_regslave i2c_regslave_chk #(.NREG(NREG), .TIME_BYTES(TIME_BYTES), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_ev    (start_ev),
  .stop_ev     (stop_ev),
  .ptr_inc     (ptr_inc),
  .ptr_q       (ptr_q),
  .busy        (busy),
  .sda_oe      (sda_oe_o),
  .live_time   (live_time_i),
  .shadow      (shadow),
  .flag_set    (flag_set_i),
  .status      (status_o),
  .time_wr     (time_wr_o),
  .time_wr_idx (time_wr_idx_o)
);

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [55:0] live = '0;
  logic [7:0]  flag_set = '0;
  logic        time_wr;
  logic [3:0]  time_wr_idx;
  logic [7:0]  time_wr_data;
  logic [63:0] cfg;
  logic [7:0]  status;
  logic        sda_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] tw_seen [7];
  int         tw_cnt = 0;
  logic [3:0] tw_last_idx = '0;
  logic [7:0] tw_last_data = '0;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regslave u_i2c_regslave (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl),
    .sda_i          (sda_line),
    .sda_oe_o       (sda_oe),
    .live_time_i    (live),
    .flag_set_i     (flag_set),
    .time_wr_o      (time_wr),
    .time_wr_idx_o  (time_wr_idx),
    .time_wr_data_o (time_wr_data),
    .cfg_regs_o     (cfg),
    .status_o       (status)
  );

  always @(posedge clk) begin
    if (rst_n && time_wr) begin
      tw_seen[time_wr_idx[2:0]] <= time_wr_data;
      tw_last_idx  <= time_wr_idx;
      tw_last_data <= time_wr_data;
      tw_cnt       <= tw_cnt + 1;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'h5A + 8'(i * 37);
  endfunction

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    ack = ~sda_line;
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq();
      scl = 1'b1; wq();
      b = {b[6:0], sda_line};
      wq();
      scl = 1'b0;
    end
    sda_m = nack; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  // Set the pointer with a write transfer, leaving the bus open for a repeated START.
  task automatic set_ptr(input logic [7:0] p);
    logic a;
    i2c_start();
    wbyte(8'hD0, a); chk("R1 own write address acked", a, 1'b1);
    wbyte(p, a);     chk("R2 pointer byte acked", a, 1'b1);
  endtask

  initial begin
    logic       a;
    logic [7:0] b;
    logic [63:0] exp_cfg;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    chk("R11 sda released", sda_oe, 1'b0);
    chk("R11 status zero", status, 8'h00);
    chk("R11 storage zero", cfg, 64'h0);

    // R1: sweep of every address, write direction
    for (int ad = 0; ad < 128; ad++) begin
      i2c_start();
      wbyte({7'(ad), 1'b0}, a);
      chk("R1 address acknowledge", a, (ad == 'h68));
      if (ad == 'h69 || ad == 'h48 || ad == 'h00) begin
        wbyte(8'h07, a); chk("R12 no ack after foreign address", a, 1'b0);
        wbyte(8'hEE, a); chk("R12 no ack after foreign address", a, 1'b0);
      end
      i2c_stop();
    end
    chk("R1 foreign transfers store nothing", cfg, 64'h0);

    // R2 / R8: burst write of the storage bytes
    set_ptr(8'h07);
    exp_cfg = '0;
    for (int i = 0; i < 8; i++) begin
      wbyte(pat(i), a);
      chk("R2 data byte acked", a, 1'b1);
      exp_cfg[8*i +: 8] = pat(i);
    end
    i2c_stop();
    chk("R8 storage bus contents", cfg, exp_cfg);

    // R4: pointer write, repeated START, read back
    set_ptr(8'h09);
    i2c_start();
    wbyte(8'hD1, a); chk("R1 own read address acked", a, 1'b1);
    for (int i = 2; i < 8; i++) begin
      rbyte(i == 7, b);
      chk("R4 read back storage", b, pat(i));
    end
    chk("R10 released after NACK", sda_oe, 1'b0);
    i2c_stop();

    // R4: read from the remembered pointer (now 0Fh)
    i2c_start();
    wbyte(8'hD1, a);
    rbyte(1'b1, b);
    chk("R4 read at persisting pointer", b, 8'h00);
    i2c_stop();

    // R9: flags
    @(negedge clk) flag_set = 8'hFF;
    @(negedge clk) flag_set = 8'h00;
    repeat (2) @(negedge clk);
    chk("R9 only mask bits set", status, 8'h83);
    set_ptr(8'h0F);
    wbyte(8'hFF, a);
    i2c_stop();
    chk("R9 writing ones keeps flags", status, 8'h83);
    set_ptr(8'h0F);
    wbyte(8'h7E, a);
    i2c_stop();
    chk("R9 writing zeros clears flags", status, 8'h02);
    set_ptr(8'h0F);
    i2c_start();
    wbyte(8'hD1, a);
    rbyte(1'b1, b);
    i2c_stop();
    chk("R9 status reads back", b, 8'h02);

    // R7: time writes
    set_ptr(8'h00);
    for (int i = 0; i < 7; i++) wbyte(8'h10 + 8'(3 * i), a);
    i2c_stop();
    chk("R7 time strobe count", tw_cnt, 7);
    for (int i = 0; i < 7; i++) chk("R7 time byte forwarded", tw_seen[i], 8'h10 + 8'(3 * i));

    // R5: coherent burst while time changes
    for (int i = 0; i < 7; i++) live[8*i +: 8] = 8'h40 + 8'(i);
    set_ptr(8'h00);
    i2c_stop();
    i2c_start();
    wbyte(8'hD1, a);
    for (int i = 0; i < 7; i++) begin
      rbyte(i == 6, b);
      if (i == 0) for (int k = 0; k < 7; k++) live[8*k +: 8] = 8'h80 + 8'(k);
      chk("R5 burst sees START instant", b, 8'h40 + 8'(i));
    end
    chk("R10 released after NACK", sda_oe, 1'b0);
    i2c_stop();
    set_ptr(8'h00);
    i2c_start();
    wbyte(8'hD1, a);
    rbyte(1'b1, b);
    i2c_stop();
    chk("R5 new START refreshes shadow", b, 8'h80);

    // R6 / R3: read wraps past 0Fh and refreshes
    set_ptr(8'h0F);
    i2c_start();
    wbyte(8'hD1, a);
    for (int k = 0; k < 7; k++) live[8*k +: 8] = 8'hC0 + 8'(k);
    rbyte(1'b0, b);
    chk("R3 read at 0Fh before wrap", b, 8'h02);
    rbyte(1'b1, b);
    chk("R6 wrap to 00h refreshes shadow", b, 8'hC0);
    i2c_stop();

    // R3: write wraps past 0Fh
    set_ptr(8'h0E);
    wbyte(8'h77, a);
    wbyte(8'hFF, a);
    wbyte(8'h99, a);
    chk("R3 byte after wrap acked", a, 1'b1);
    i2c_stop();
    chk("R3 storage at 0Eh", cfg[63:56], 8'h77);
    chk("R3 flags kept by ones", status, 8'h02);
    chk("R3 wrapped write index", tw_last_idx, 4'h0);
    chk("R3 wrapped write data", tw_last_data, 8'h99);
    chk("R12 idle releases SDA", sda_oe, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule